// File: doc/BRIEF.md
# Codec Channel Mode and Power-Down Controller

This block works out the operating state of a voice codec from what its two frame-sync inputs and its combined receive-clock/power-down pin are doing. A free-running reference clock samples every input through a two-stage synchronizer. For each monitored input, a per-input timer records whether an edge has been seen recently. The codec runs in one of four states: full duplex, transmit half-channel, receive half-channel or power-down. The choice depends on which frame syncs are clocking and on whether the power-down pin is held high.

Beside the mode, the block picks the master clock that feeds the converter core. It also reports the master-clock frequency that the clock-select pin implies for the chosen companding variant, and flags when one bit clock must serve both directions. Its transmit-output enable keeps the serial transmit pins in high impedance after a power-up until two transmit frame syncs have arrived. A receive-data enable tells the receive path whether to accept PCM data.

Top module: `codec_mode_ctrl`

## Requirements
- R1: Transmit frame sync clocking with receive frame sync static gives `mode` = 2 (transmit half-channel), and `rx_en` is 0 so receive PCM data is ignored.
- R2: Receive frame sync clocking with transmit frame sync static gives `mode` = 3 (receive half-channel), and `tx_oe` stays 0.
- R3: Both frame syncs clocking gives `mode` = 1 (full duplex) with `rx_en` = 1.
- R4: When neither frame sync is clocking, the previous mode is held until PD_DELAY reference cycles have passed since the last edge on either frame sync. `mode` then becomes 0 (power-down).
- R5: `rx_mclk_pd` held statically high forces `mode` = 0 within ACT_WIN+4 cycles, whatever the frame syncs are doing.
- R6: `mode` leaves 0 only with `rx_mclk_pd` low or clocking and a frame sync clocking. `tx_oe` stays 0 until the second rising edge of the transmit frame sync after power-up. `tx_oe` is always 0 in modes 0 and 3.
- R7: In mode 3 with `rx_mclk_pd` clocking, `core_mclk` follows `rx_mclk_pd`. In every other case it follows `tx_mclk`.
- R8: `bclk_shared` is 1 when `clk_sel` is at a static level and 0 while it is clocking.
- R9: `freq_code` uses 0 for 1.536 MHz, 1 for 1.544 MHz and 2 for 2.048 MHz. With ALAW=0, a static-low `clk_sel` gives 2 and any other `clk_sel` gives 0. With ALAW=1, a static-low `clk_sel` gives 1 and any other gives 2.
- R10: An input counts as clocking while an edge has been seen, after its two-stage synchronizer, within the last ACT_WIN reference cycles.
- R11: After reset, `mode` is 0 and `tx_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_fsync | input | 1 | Transmit frame sync |
| rx_fsync | input | 1 | Receive frame sync |
| tx_mclk | input | 1 | Transmit master clock |
| rx_mclk_pd | input | 1 | Receive master clock, or power-down request when held high |
| clk_sel | input | 1 | Clock-select pin: static level or a bit clock |
| mode | output | 2 | 0 power-down, 1 full duplex, 2 transmit half, 3 receive half |
| core_mclk | output | 1 | Master clock chosen for the core |
| freq_code | output | 2 | Expected master-clock frequency code |
| tx_oe | output | 1 | Transmit serial output enable |
| rx_en | output | 1 | Receive PCM data accepted |
| bclk_shared | output | 1 | One bit clock serves both directions |

## Verification
The case that is hardest to reach from the ports is the idle power-down window. Both frame syncs must stop, and the bench must then observe the mode held through the whole delay before it drops at the exact cycle, with no stray edge restarting the count. The stimulus stops both syncs from a running receive half-channel state. It samples partway through the delay and again after it, while a cycle-by-cycle model checks the exact drop cycle. A forced power-down with frame syncs still running, followed by a fresh power-up, exercises the two-pulse gate on the transmit enable.

// File: rtl/codec_mode_ctrl.sv
module codec_mode_ctrl #(
  parameter int ALAW     = 0,
  parameter int ACT_WIN  = 64,
  parameter int PD_DELAY = 500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_fsync,
  input  logic       rx_fsync,
  input  logic       tx_mclk,
  input  logic       rx_mclk_pd,
  input  logic       clk_sel,
  output logic [1:0] mode,
  output logic       core_mclk,
  output logic [1:0] freq_code,
  output logic       tx_oe,
  output logic       rx_en,
  output logic       bclk_shared
);
  localparam int AW = $clog2(ACT_WIN + 1);
  localparam int PW = $clog2(PD_DELAY + 1);
  localparam logic [1:0] M_PD = 2'd0, M_FULL = 2'd1, M_TXH = 2'd2, M_RXH = 2'd3;

  logic [3:0] s1, s2, s3, edg, act;
  logic [1:0] mode_q, mode_d, oe_cnt;
  logic [PW-1:0] pd_cnt;
  logic forced_pd, fs_edge, tx_rise;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= {clk_sel, rx_mclk_pd, rx_fsync, tx_fsync};
      s2 <= s1;
      s3 <= s2;
    end

  assign edg = s2 ^ s3;

  for (genvar g = 0; g < 4; g++) begin : g_act
    logic [AW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) cnt <= AW'(ACT_WIN);
      else if (edg[g]) cnt <= '0;
      else if (cnt != AW'(ACT_WIN)) cnt <= cnt + 1'b1;
    assign act[g] = (cnt != AW'(ACT_WIN));
    a_r10_timer_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= AW'(ACT_WIN));
  end

  assign forced_pd = s2[2] & ~act[2];
  assign fs_edge   = edg[0] | edg[1];
  assign tx_rise   = s2[0] & ~s3[0];

  always_comb begin
    mode_d = mode_q;
    if (forced_pd)                mode_d = M_PD;
    else if (act[0] && act[1])    mode_d = M_FULL;
    else if (act[0])              mode_d = M_TXH;
    else if (act[1])              mode_d = M_RXH;
    else if (pd_cnt == PW'(PD_DELAY)) mode_d = M_PD;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_q <= M_PD;
      pd_cnt <= '0;
      oe_cnt <= '0;
    end else begin
      mode_q <= mode_d;
      if (fs_edge) pd_cnt <= '0;
      else if (pd_cnt != PW'(PD_DELAY)) pd_cnt <= pd_cnt + 1'b1;
      if (mode_d == M_PD) oe_cnt <= '0;
      else if (tx_rise && oe_cnt != 2'd2) oe_cnt <= oe_cnt + 1'b1;
    end

  assign mode        = mode_q;
  assign tx_oe       = (oe_cnt == 2'd2) && (mode_q == M_FULL || mode_q == M_TXH);
  assign rx_en       = (mode_q == M_FULL) || (mode_q == M_RXH);
  assign core_mclk   = (mode_q == M_RXH && act[2]) ? rx_mclk_pd : tx_mclk;
  assign bclk_shared = ~act[3];
  assign freq_code   = (ALAW != 0) ? ((~s2[3] & ~act[3]) ? 2'd1 : 2'd2)
                                   : ((~s2[3] & ~act[3]) ? 2'd2 : 2'd0);

  a_r6_no_oe_at_wake: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) == M_PD) |-> !tx_oe);

  a_r4_pd_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) != M_PD && mode_q == M_PD) |->
      ($past(forced_pd) || $past(pd_cnt) == PW'(PD_DELAY)));

  a_r6_wake_needs_sync: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) == M_PD && mode_q != M_PD) |->
      ($past(act[0] | act[1]) && !$past(forced_pd)));

  a_r5_forced_holds_pd: assert property (@(posedge clk) disable iff (!rst_n)
    forced_pd |=> (mode_q == M_PD));

  a_r11_oe_counter_range: assert property (@(posedge clk) disable iff (!rst_n)
    oe_cnt <= 2'd2);
endmodule

// File: tb/tb_codec_mode_ctrl.sv
`timescale 1ns/1ps
module tb_codec_mode_ctrl;
  localparam int W = 16;
  localparam int PD = 200;

  logic clk = 0, rst_n = 0;
  logic tx_fsync = 0, rx_fsync = 0, tx_mclk = 0, rx_mclk_pd = 0, clk_sel = 1;
  logic [1:0] mode, freq_code, mode_a, freq_a;
  logic core_mclk, tx_oe, rx_en, bclk_shared, core_a, oe_a, rxen_a, bs_a;

  int checks = 0, fails = 0, cyc = 0, ph = 0;
  int tx_on = 0, rx_on = 0, rp_mode = 0, sel_mode = 1;

  always #2 clk = ~clk;

  codec_mode_ctrl #(.ALAW(0), .ACT_WIN(W), .PD_DELAY(PD)) dut (
    .clk(clk), .rst_n(rst_n), .tx_fsync(tx_fsync), .rx_fsync(rx_fsync),
    .tx_mclk(tx_mclk), .rx_mclk_pd(rx_mclk_pd), .clk_sel(clk_sel),
    .mode(mode), .core_mclk(core_mclk), .freq_code(freq_code), .tx_oe(tx_oe),
    .rx_en(rx_en), .bclk_shared(bclk_shared));

  codec_mode_ctrl #(.ALAW(1), .ACT_WIN(W), .PD_DELAY(PD)) dut_a (
    .clk(clk), .rst_n(rst_n), .tx_fsync(tx_fsync), .rx_fsync(rx_fsync),
    .tx_mclk(tx_mclk), .rx_mclk_pd(rx_mclk_pd), .clk_sel(clk_sel),
    .mode(mode_a), .core_mclk(core_a), .freq_code(freq_a), .tx_oe(oe_a),
    .rx_en(rxen_a), .bclk_shared(bs_a));

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(negedge clk) begin
    ph++;
    tx_mclk    <= ~tx_mclk;
    tx_fsync   <= (tx_on != 0) && (ph % 12 < 3);
    rx_fsync   <= (rx_on != 0) && ((ph + 5) % 12 < 3);
    rx_mclk_pd <= (rp_mode == 2) ? ph[0] : (rp_mode == 1);
    clk_sel    <= (sel_mode == 2) ? ph[2] : (sel_mode == 1);
  end

  // behavioural reference model
  int d1[4], d2[4], d3[4], since[4];
  int m_mode = 0, m_pdc = 0, m_oec = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, 100000);
      finish_run();
    end
    if (!rst_n) begin
      foreach (since[i]) begin since[i] = W; d1[i] = 0; d2[i] = 0; d3[i] = 0; end
      m_mode = 0; m_pdc = 0; m_oec = 0;
    end else begin
      bit a[4], e[4], frc, rise;
      int nm;
      foreach (since[i]) begin
        a[i] = since[i] < W;
        e[i] = d2[i] != d3[i];
      end
      frc  = (d2[2] == 1) && !a[2];
      rise = (d2[0] == 1) && (d3[0] == 0);
      nm = m_mode;
      if (frc) nm = 0;
      else if (a[0] && a[1]) nm = 1;
      else if (a[0]) nm = 2;
      else if (a[1]) nm = 3;
      else if (m_pdc == PD) nm = 0;
      if (e[0] || e[1]) m_pdc = 0; else if (m_pdc < PD) m_pdc++;
      if (nm == 0) m_oec = 0; else if (rise && m_oec < 2) m_oec++;
      m_mode = nm;
      foreach (since[i]) begin
        if (e[i]) since[i] = 0; else if (since[i] < W) since[i]++;
        d3[i] = d2[i]; d2[i] = d1[i];
      end
      d1[0] = tx_fsync; d1[1] = rx_fsync; d1[2] = rx_mclk_pd; d1[3] = clk_sel;
      #1;
      begin
        bit slow, ract;
        slow = (d2[3] == 0) && !(since[3] < W);
        ract = since[2] < W;
        check("R1-R4 mode", mode, m_mode);
        check("R6 tx_oe", tx_oe, (m_oec == 2) && (m_mode == 1 || m_mode == 2));
        check("R1 rx_en", rx_en, (m_mode == 1 || m_mode == 3));
        check("R7 core_mclk", core_mclk,
              (m_mode == 3 && ract) ? rx_mclk_pd : tx_mclk);
        check("R8 bclk_shared", bclk_shared, !(since[3] < W));
        check("R9 freq mu", freq_code, slow ? 2 : 0);
        check("R9 freq A", freq_a, slow ? 1 : 2);
      end
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_cyc(5);
    check("R11 reset mode", mode, 0);
    check("R11 reset tx_oe", tx_oe, 0);
    rst_n = 1;
    rp_mode = 2;
    tx_on = 1;
    wait (mode != 0);
    @(negedge clk);
    check("R6 oe low right after wake", tx_oe, 0);
    wait_cyc(100);
    check("R1 tx half mode", mode, 2);
    check("R1 rx data ignored", rx_en, 0);
    check("R6 oe after two syncs", tx_oe, 1);
    rx_on = 1; wait_cyc(100);
    check("R3 full duplex", mode, 1);
    check("R3 rx_en", rx_en, 1);
    tx_on = 0; wait_cyc(100);
    check("R2 rx half", mode, 3);
    check("R2 tx_oe off", tx_oe, 0);
    for (int k = 0; k < 4; k++) begin
      #0.5 check("R7 rx clock chosen", core_mclk, rx_mclk_pd);
      @(negedge clk);
    end
    rp_mode = 0; wait_cyc(50);
    #0.5 check("R7 tx clock fallback", core_mclk, tx_mclk);
    rx_on = 0; wait_cyc(100);
    check("R4 mode held during delay", mode, 3);
    wait_cyc(200);
    check("R4 idle power-down", mode, 0);
    tx_on = 1; wait_cyc(60);
    check("R6 wake by tx sync", mode, 2);
    rp_mode = 1; wait_cyc(40);
    check("R5 forced power-down", mode, 0);
    wait_cyc(100);
    check("R5 syncs do not wake", mode, 0);
    check("R5 oe off", tx_oe, 0);
    rp_mode = 0; wait_cyc(60);
    check("R6 wake after release", mode, 2);
    check("R6 oe restored", tx_oe, 1);
    sel_mode = 0; wait_cyc(40);
    check("R9 mu low", freq_code, 2);
    check("R9 A low", freq_a, 1);
    check("R8 static shares", bclk_shared, 1);
    sel_mode = 2; wait_cyc(40);
    check("R9 mu clocked", freq_code, 0);
    check("R9 A clocked", freq_a, 2);
    check("R8 clocked separate", bclk_shared, 0);
    check("R10 sel counted as clocking", bs_a, 0);
    sel_mode = 1; wait_cyc(40);
    check("R9 mu high", freq_code, 0);
    check("R8 high shares", bclk_shared, 1);
    finish_run();
  end
endmodule